// File: doc/BRIEF.md
# Signed-Digit Carry-Free Adder

This block adds two operands held in redundant signed-digit form. Each of the N digit positions holds a value of -1, 0 or +1. The sum has N+1 digits. It is formed in two combinational phases. In the first phase, every position turns the two digits it receives into a transfer digit for the position above and an interim digit that it keeps. In the second phase, every position adds its interim digit to the transfer arriving from the position below.

The first phase looks at the digits one position lower before it picks its split. Because of this, the second phase can never leave the set {-1, 0, +1}, and a carry never travels more than one position. The logic depth is therefore the same for any N. The result stays in signed-digit form and is never turned into binary inside the block.

An optional output register gives one cycle of latency and clears on reset. The block suits wide accumulation paths where a binary carry chain would limit the clock rate.

Top module: `sd_cf_adder`

## Requirements
- R1: Each digit is 2 bits, {sign, magnitude}: 2'b01 is +1, 2'b11 is -1, 2'b00 is zero. Digit i of a vector occupies bits [2i+1:2i].
- R2: The weighted value of the N+1 result digits (digit i weighs 2^i) equals the sum of the weighted values of the two operands.
- R3: Every result digit is -1, 0 or +1, and a zero result digit is always encoded as 2'b00, never as 2'b10.
- R4: An operand digit encoded 2'b10 is treated as zero.
- R5: When the digits at a position sum to +2 or -2, that position sends a transfer of +1 or -1 and keeps an interim of 0. When they sum to 0, both the transfer and the interim are 0.
- R6: When the digits at position i sum to +1, the split depends on the two digits at position i-1. If neither is negative, the transfer is +1 and the interim is -1; otherwise the transfer is 0 and the interim is +1. When the digits sum to -1 and neither lower digit is negative, the transfer is 0 and the interim is -1; otherwise the transfer is -1 and the interim is +1. Position 0 sees lower digits of zero.
- R7: Position 0 receives a transfer of 0, and result digit N is the transfer sent out by position N-1.
- R8: With REG_OUT=1, the result appears on the clock edge after the operands are applied. While rst_n is low, every result digit is 2'b00.
- R9: The interim digit plus the incoming transfer at every position always lies within {-1, 0, +1}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 2*N | First operand, N signed digits |
| op_b | input | 2*N | Second operand, N signed digits |
| sum_o | output | 2*(N+1) | Result, N+1 signed digits |

## Verification
The directed cases exercise both branches of the lookahead rule for a +1 sum and for a -1 sum. A design that ignores the lower digits would produce a result digit of +2 or -2, which encodes as zero, so the weighted value comes out wrong. All-plus-one and all-minus-one operands exercise every position at once and show whether the top transfer reaches digit N; a design that drops it loses the most significant digit. Operands that use the 2'b10 zero code expose a decoder that reads the sign bit without the magnitude bit, because the sum then shifts by one unit. Random operands checked by value and by encoding catch any result digit that overflows or comes out as a negative zero.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef logic [1:0] sd_digit_t;

    localparam sd_digit_t SD_ZERO = 2'b00;
    localparam sd_digit_t SD_POS  = 2'b01;
    localparam sd_digit_t SD_NEG  = 2'b11;

    // Zero for either sign when the magnitude bit is clear
    function automatic int sd_to_int(input sd_digit_t d);
        if (!d[0]) return 0;
        return d[1] ? -1 : 1;
    endfunction

    function automatic logic sd_is_neg(input sd_digit_t d);
        return d[1] & d[0];
    endfunction

    // Always emits the canonical zero code
    function automatic sd_digit_t int_to_sd(input int v);
        if (v == 1)  return SD_POS;
        if (v == -1) return SD_NEG;
        return SD_ZERO;
    endfunction
endpackage

// File: rtl/sd_xfer_cell.sv
module sd_xfer_cell
    import sd_pkg::*;
(
    input  sd_digit_t a_i,
    input  sd_digit_t b_i,
    input  sd_digit_t lo_a_i,
    input  sd_digit_t lo_b_i,
    output sd_digit_t xfer_o,
    output sd_digit_t interim_o
);
    int   pair;
    logic lo_nonneg;

    always_comb begin
        pair      = sd_to_int(a_i) + sd_to_int(b_i);
        lo_nonneg = !sd_is_neg(lo_a_i) && !sd_is_neg(lo_b_i);
        xfer_o    = SD_ZERO;
        interim_o = SD_ZERO;
        case (pair)
            2:  xfer_o = SD_POS;
            -2: xfer_o = SD_NEG;
            1: begin
                if (lo_nonneg) begin
                    xfer_o    = SD_POS;
                    interim_o = SD_NEG;
                end else begin
                    interim_o = SD_POS;
                end
            end
            -1: begin
                if (lo_nonneg) begin
                    interim_o = SD_NEG;
                end else begin
                    xfer_o    = SD_NEG;
                    interim_o = SD_POS;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sd_sum_cell.sv
module sd_sum_cell
    import sd_pkg::*;
(
    input  sd_digit_t interim_i,
    input  sd_digit_t xfer_i,
    output sd_digit_t digit_o
);
    always_comb begin
        digit_o = int_to_sd(sd_to_int(interim_i) + sd_to_int(xfer_i));
    end
endmodule

// File: rtl/sd_out_stage.sv
module sd_out_stage #(
    parameter int W   = 34,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_o <= '0;
                else        q_o <= d_i;
            end
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/sd_cf_adder.sv
module sd_cf_adder
    import sd_pkg::*;
#(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*N-1:0]       op_a,
    input  logic [2*N-1:0]       op_b,
    output logic [2*(N+1)-1:0]   sum_o
);
    localparam int W_OUT = 2 * (N + 1);

    sd_digit_t xfer    [N];
    sd_digit_t xfer_in [N];
    sd_digit_t interim [N];
    logic [W_OUT-1:0] comb_sum;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pos
            sd_digit_t lo_a, lo_b;
            if (i == 0) begin : g_lsb
                assign lo_a       = SD_ZERO;
                assign lo_b       = SD_ZERO;
                assign xfer_in[i] = SD_ZERO;   // R7
            end else begin : g_upper
                assign lo_a       = op_a[2*i-1 -: 2];
                assign lo_b       = op_b[2*i-1 -: 2];
                assign xfer_in[i] = xfer[i-1];
            end

            sd_xfer_cell u_xfer (
                .a_i       (op_a[2*i +: 2]),
                .b_i       (op_b[2*i +: 2]),
                .lo_a_i    (lo_a),
                .lo_b_i    (lo_b),
                .xfer_o    (xfer[i]),
                .interim_o (interim[i])
            );

            sd_sum_cell u_sum (
                .interim_i (interim[i]),
                .xfer_i    (xfer_in[i]),
                .digit_o   (comb_sum[2*i +: 2])
            );

            // R9
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sd_to_int(interim[i]) + sd_to_int(xfer_in[i])) inside {-1, 0, 1});
        end
    endgenerate

    assign comb_sum[W_OUT-1 -: 2] = xfer[N-1];   // R7: top digit

    sd_out_stage #(.W(W_OUT), .REG(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (comb_sum),
        .q_o   (sum_o)
    );

    // ---------------- checks ----------------
    function automatic longint vec_val(input logic [W_OUT-1:0] v);
        longint acc = 0;
        for (int j = N; j >= 0; j--) acc = acc * 2 + longint'(sd_to_int(v[2*j +: 2]));
        return acc;
    endfunction

    generate
        for (genvar j = 0; j <= N; j++) begin : g_canon
            // R3
            canon_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(sum_o[2*j+1] && !sum_o[2*j]));
        end

        if (REG_OUT) begin : g_reg_chk
            logic past_ok;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) past_ok <= 1'b0;
                else        past_ok <= 1'b1;
            end
            // R2
            value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok |-> vec_val(sum_o) == $past(vec_val({2'b00, op_a}) + vec_val({2'b00, op_b})));
            // R8
            reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !past_ok |-> sum_o == '0);
        end else begin : g_comb_chk
            // R2
            value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                vec_val(sum_o) == vec_val({2'b00, op_a}) + vec_val({2'b00, op_b}));
        end
    endgenerate
endmodule

// File: tb/sim_sd_cf_adder.sv
module sim_sd_cf_adder;
    localparam int N  = 16;
    localparam int WI = 2 * N;
    localparam int WO = 2 * (N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WI-1:0] op_a = '0;
    logic [WI-1:0] op_b = '0;
    logic [WO-1:0] sum_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sd_cf_adder #(.N(N), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_o(sum_o)
    );

    function automatic int dval(input logic [1:0] d);
        if (!d[0]) return 0;
        return d[1] ? -1 : 1;
    endfunction

    function automatic longint val(input logic [WO-1:0] v);
        longint acc = 0;
        for (int j = N; j >= 0; j--) acc = acc * 2 + longint'(dval(v[2*j +: 2]));
        return acc;
    endfunction

    function automatic logic [WI-1:0] mk(input int pos, input logic [1:0] code);
        logic [WI-1:0] r = '0;
        r[2*pos +: 2] = code;
        return r;
    endfunction

    function automatic logic [WO-1:0] mko(input int pos, input logic [1:0] code);
        logic [WO-1:0] r = '0;
        r[2*pos +: 2] = code;
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [WO-1:0] got, input logic [WO-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [WO-1:0] got, input longint exp);
        n_checks++;
        if (val(got) != exp) begin
            n_fail++;
            $display("FAIL %s: value %0d expected %0d", req, val(got), exp);
        end
    endtask

    task automatic check_canon(input string req, input logic [WO-1:0] got);
        bit bad = 1'b0;
        for (int j = 0; j <= N; j++) if (got[2*j +: 2] == 2'b10) bad = 1'b1;
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: got %h expected no 2'b10 digit", req, got);
        end
    endtask

    task automatic apply(input logic [WI-1:0] a, input logic [WI-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    function automatic logic [WI-1:0] rnd_op();
        logic [WI-1:0] r;
        for (int j = 0; j < N; j++) r[2*j +: 2] = 2'($urandom % 4);
        return r;
    endfunction

    initial begin
        logic [WO-1:0] exp_all;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check_vec("R8 reset clear", sum_o, '0);
        rst_n = 1'b1;

        // R1: single -1 digit passes through unchanged
        apply(mk(0, 2'b11), '0);
        check_vec("R1 -1 code", sum_o, mko(0, 2'b11));

        // R5: +2, -2 and 0 digit sums
        apply(mk(0, 2'b01), mk(0, 2'b01));
        check_vec("R5 sum +2", sum_o, mko(1, 2'b01));
        apply(mk(3, 2'b11), mk(3, 2'b11));
        check_vec("R5 sum -2", sum_o, mko(4, 2'b11));
        apply(mk(2, 2'b01), mk(2, 2'b11));
        check_vec("R5 sum 0", sum_o, '0);

        // R6: lookahead branches
        apply(mk(1, 2'b01), '0);
        check_vec("R6 +1 lower nonneg", sum_o, mko(2, 2'b01) | mko(1, 2'b11));
        apply(mk(1, 2'b01), mk(0, 2'b11));
        check_vec("R6 +1 lower neg", sum_o, mko(1, 2'b01) | mko(0, 2'b11));
        apply(mk(1, 2'b11), '0);
        check_vec("R6 -1 lower nonneg", sum_o, mko(1, 2'b11));
        apply(mk(1, 2'b11), mk(0, 2'b11));
        check_vec("R6 -1 lower neg", sum_o, mko(2, 2'b11) | mko(1, 2'b01) | mko(0, 2'b11));

        // R7: every position transfers, top digit receives it
        exp_all = '0;
        for (int j = 1; j <= N; j++) exp_all[2*j +: 2] = 2'b01;
        apply({N{2'b01}}, {N{2'b01}});
        check_vec("R7 all +1", sum_o, exp_all);
        for (int j = 1; j <= N; j++) exp_all[2*j +: 2] = 2'b11;
        apply({N{2'b11}}, {N{2'b11}});
        check_vec("R7 all -1", sum_o, exp_all);

        // R4: 2'b10 reads as zero
        apply(mk(0, 2'b10), mk(0, 2'b01));
        check_vec("R4 neg-zero code", sum_o, mko(1, 2'b01) | mko(0, 2'b11));
        apply({N{2'b10}}, '0);
        check_vec("R4 all neg-zero", sum_o, '0);

        // R8: output holds until the next clock edge
        @(negedge clk);
        op_a = mk(5, 2'b01);
        op_b = '0;
        #2;
        check_vec("R8 latency hold", sum_o, '0);
        @(negedge clk);
        check_val("R8 latency update", sum_o, 64'sd32);

        // R2, R3, R9: random operands
        for (int k = 0; k < 400; k++) begin
            logic [WI-1:0] a, b;
            a = rnd_op();
            b = rnd_op();
            apply(a, b);
            check_val("R2/R9 random value", sum_o, val({2'b00, a}) + val({2'b00, b}));
            check_canon("R3 random canonical", sum_o);
        end

        // R8: reset clears a nonzero result
        apply({N{2'b01}}, '0);
        rst_n = 1'b0;
        #2;
        check_vec("R8 reset clear again", sum_o, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule